// File: doc/BRIEF.md
# Multi-Field Floating-Point Status Register

This block holds the 64-bit control and status word for a floating-point unit. The word has six global trap-enable masks and four independent 13-bit status fields. Each field carries a rounding mode, a precision, a wide-exponent bit, a flush-to-zero bit, a trap-suppress bit and six sticky exception flags. Several computations can run at once, each with its own rounding and precision, by selecting a different field.

Software reads the word and writes it with byte enables. The execution pipe reports results through an update port. Each update names a field and gives a six-bit exception vector. The block either sets the sticky flags of that field or, when an exception is enabled, raises a registered trap request that carries the enabled causes. A separate selector exports the controls of one field to the datapath.

Top module: `fp_status_reg`

## Requirements
- R1: Synchronous reset sets all six masks to 1. Field 0 resets to rounding 00 (nearest), precision 11 (64-bit), wide 0. Fields 1 to 3 reset to rounding 00, precision 11, wide 1. All ftz, td and flag bits reset to 0, and trap_req resets to 0.
- R2: Masks sit at bits 5:0, in the order invalid(0), zero-divide(1), overflow(2), underflow(3), inexact(4), denormal(5). Field k sits at bits 6+13k to 18+13k, with internal bits ftz(0), wide(1), precision(3:2), rounding(5:4), td(6), and flags at 12:7 in the order invalid, denormal, zero-divide, overflow, underflow, inexact. Bits 63:58 read as 0.
- R3: upd_exc uses the mask order. One cycle after an update, trap_req is 1 exactly when some reported exception has mask 0 and td is not in effect. trap_cause then holds those enabled exceptions.
- R4: In fields 1 to 3, td = 1 suppresses every trap for updates to that field, whatever the masks.
- R5: In field 0, td is reserved. It reads as 0 after any write and never suppresses a trap.
- R6: An update that raises no trap ORs its exceptions into the selected field's flags. Flags are never cleared except by a software write or by reset.
- R7: An update that raises a trap leaves every flag unchanged.
- R8: When a software write and an update fall in the same cycle, the written bytes take the written value. Bytes that are not written take the update's effect.
- R9: Precision code 01 is reserved. A write of 01 stores 11.
- R10: ctl_rc, ctl_pc, ctl_wre and ctl_ftz show the current stored controls of the field chosen by ctl_sel. ctl_td shows that field's td, forced to 0 for field 0.
- R11: Bytes whose sw_wbe bit is 0 keep their value during a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write strobe |
| sw_wbe | input | 8 | Byte enables for the write |
| sw_wdata | input | 64 | Write data |
| sw_rdata | output | 64 | Current register contents |
| upd_valid | input | 1 | Execution update strobe |
| upd_sf | input | 2 | Status field index of the update |
| upd_exc | input | 6 | Reported exceptions, in mask order |
| ctl_sel | input | 2 | Field whose controls are exported |
| ctl_rc | output | 2 | Rounding mode of the selected field |
| ctl_pc | output | 2 | Precision of the selected field |
| ctl_wre | output | 1 | Wide exponent bit of the selected field |
| ctl_ftz | output | 1 | Flush-to-zero bit of the selected field |
| ctl_td | output | 1 | Effective trap-suppress bit of the selected field |
| trap_req | output | 1 | Registered trap request |
| trap_cause | output | 6 | Enabled exceptions behind trap_req |

## Verification
The two actions that can collide are a software write and a flag update in the same cycle. The bench provokes this twice on field 3. In the first case only the mask byte is written, so the new flags must appear next to the new masks. In the second case the bytes that hold field 3's flags are written, so the written zeros must win over the reported exception. A scoreboard model applies the update first and the write after it, per byte, and compares the readback, trap outputs and exported controls after every cycle. The pseudo-random phase produces many more such collisions.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int SF_W  = 13;
  localparam int EXC_W = 6;
  localparam int SF_LSB = EXC_W;

  localparam logic [1:0] PC_24  = 2'b00;
  localparam logic [1:0] PC_RSV = 2'b01;
  localparam logic [1:0] PC_53  = 2'b10;
  localparam logic [1:0] PC_64  = 2'b11;
  localparam logic [1:0] RC_NEAR = 2'b00;

  // packed MSB first: ftz lands on bit 0
  typedef struct packed {
    logic [5:0] flags;  // v d z o u i from bit 7 up
    logic       td;
    logic [1:0] rc;
    logic [1:0] pc;
    logic       wre;
    logic       ftz;
  } field_t;

  localparam field_t SF_USER_RST = '{flags: 6'd0, td: 1'b0, rc: RC_NEAR, pc: PC_64, wre: 1'b0, ftz: 1'b0};
  localparam field_t SF_WIDE_RST = '{flags: 6'd0, td: 1'b0, rc: RC_NEAR, pc: PC_64, wre: 1'b1, ftz: 1'b0};

  // exception vector order: v z o u i d ; flag order: v d z o u i
  function automatic logic [5:0] exc_to_flags(input logic [5:0] e);
    return {e[4], e[3], e[2], e[1], e[5], e[0]};
  endfunction
endpackage

// File: rtl/fpsr_field.sv
module fpsr_field
  import fpsr_pkg::*;
#(
  parameter field_t RST_VAL = SF_WIDE_RST,
  parameter bit     IS_USER = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc_en,
  input  logic [5:0]      acc_flags,
  input  logic [SF_W-1:0] wr_en,
  input  logic [SF_W-1:0] wr_data,
  output field_t          q
);
  logic [SF_W-1:0] merged;
  field_t          nxt;

  always_comb begin
    nxt = q;
    if (acc_en) nxt.flags = q.flags | acc_flags;
    merged = (SF_W'(nxt) & ~wr_en) | (wr_data & wr_en);
    nxt = field_t'(merged);
    if (nxt.pc == PC_RSV) nxt.pc = PC_64;
    if (IS_USER) nxt.td = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= nxt;
  end

  AST_PC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    q.pc != PC_RSV); // R9

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wr_en[12:7] == 6'd0) |=> ((q.flags & $past(q.flags)) == $past(q.flags))); // R6
endmodule

// File: rtl/fpsr_trap_eval.sv
module fpsr_trap_eval
  import fpsr_pkg::*;
#(
  parameter int NUM_SF = 4,
  parameter int SEL_W  = 2
) (
  input  logic [NUM_SF*SF_W-1:0] sf_flat,
  input  logic [EXC_W-1:0]       mask,
  input  logic [SEL_W-1:0]       sel,
  input  logic [EXC_W-1:0]       exc,
  output field_t                 fld,
  output logic                   td_eff,
  output logic [EXC_W-1:0]       trap_vec
);
  always_comb begin
    fld      = field_t'(sf_flat[int'(sel)*SF_W +: SF_W]);
    td_eff   = fld.td && (sel != '0);
    trap_vec = td_eff ? '0 : (exc & ~mask);
  end
endmodule

// File: rtl/fp_status_reg.sv
module fp_status_reg
  import fpsr_pkg::*;
#(
  parameter int REG_W  = 64,
  parameter int BYTE_W = 8,
  parameter int NUM_SF = 4,
  parameter int SEL_W  = $clog2(NUM_SF)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sw_we,
  input  logic [REG_W/BYTE_W-1:0] sw_wbe,
  input  logic [REG_W-1:0]        sw_wdata,
  output logic [REG_W-1:0]        sw_rdata,
  input  logic                    upd_valid,
  input  logic [SEL_W-1:0]        upd_sf,
  input  logic [EXC_W-1:0]        upd_exc,
  input  logic [SEL_W-1:0]        ctl_sel,
  output logic [1:0]              ctl_rc,
  output logic [1:0]              ctl_pc,
  output logic                    ctl_wre,
  output logic                    ctl_ftz,
  output logic                    ctl_td,
  output logic                    trap_req,
  output logic [EXC_W-1:0]        trap_cause
);
  localparam int NBYTE  = REG_W / BYTE_W;
  localparam int USED_W = SF_LSB + NUM_SF * SF_W;

  logic [REG_W-1:0]       wbit;
  logic [EXC_W-1:0]       mask_q;
  logic [NUM_SF*SF_W-1:0] sf_flat;
  logic [EXC_W-1:0]       upd_exc_v;
  logic [EXC_W-1:0]       upd_trap_vec;
  logic [EXC_W-1:0]       ctl_trap_vec;
  logic                   upd_td_eff;
  logic                   trap_hit;
  field_t                 upd_fld;
  field_t                 ctl_fld;

  for (genvar b = 0; b < NBYTE; b++) begin : g_wbit
    assign wbit[b*BYTE_W +: BYTE_W] = {BYTE_W{sw_we & sw_wbe[b]}};
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else begin
      for (int i = 0; i < EXC_W; i++)
        if (wbit[i]) mask_q[i] <= sw_wdata[i];
    end
  end

  assign upd_exc_v = upd_valid ? upd_exc : '0;

  fpsr_trap_eval #(.NUM_SF(NUM_SF), .SEL_W(SEL_W)) u_upd_eval (
    .sf_flat (sf_flat),
    .mask    (mask_q),
    .sel     (upd_sf),
    .exc     (upd_exc_v),
    .fld     (upd_fld),
    .td_eff  (upd_td_eff),
    .trap_vec(upd_trap_vec)
  );

  assign trap_hit = |upd_trap_vec;

  for (genvar k = 0; k < NUM_SF; k++) begin : g_sf
    fpsr_field #(
      .RST_VAL(k == 0 ? SF_USER_RST : SF_WIDE_RST),
      .IS_USER(k == 0)
    ) u_fld (
      .clk      (clk),
      .rst      (rst),
      .acc_en   (upd_valid && (upd_sf == SEL_W'(k)) && !trap_hit),
      .acc_flags(exc_to_flags(upd_exc)),
      .wr_en    (wbit[SF_LSB + k*SF_W +: SF_W]),
      .wr_data  (sw_wdata[SF_LSB + k*SF_W +: SF_W]),
      .q        (sf_flat[k*SF_W +: SF_W])
    );
  end

  fpsr_trap_eval #(.NUM_SF(NUM_SF), .SEL_W(SEL_W)) u_ctl_eval (
    .sf_flat (sf_flat),
    .mask    (mask_q),
    .sel     (ctl_sel),
    .exc     ('0),
    .fld     (ctl_fld),
    .td_eff  (ctl_td),
    .trap_vec(ctl_trap_vec)
  );

  assign ctl_rc  = ctl_fld.rc;
  assign ctl_pc  = ctl_fld.pc;
  assign ctl_wre = ctl_fld.wre;
  assign ctl_ftz = ctl_fld.ftz;

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req   <= 1'b0;
      trap_cause <= '0;
    end else begin
      trap_req   <= trap_hit;
      trap_cause <= upd_trap_vec;
    end
  end

  always_comb begin
    sw_rdata = '0;
    sw_rdata[EXC_W-1:0] = mask_q;
    sw_rdata[USED_W-1:SF_LSB] = sf_flat;
  end

  AST_TRAP_NEEDS_UPD: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $past(upd_valid)); // R3

  AST_MASKED_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && ((upd_exc & ~mask_q) == '0)) |=> !trap_req); // R3

  AST_TD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && (upd_sf != '0) && upd_fld.td) |=> !trap_req); // R4

  AST_USER_TD_INERT: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && (upd_sf == '0) && ((upd_exc & ~mask_q) != '0)) |=> trap_req); // R5
endmodule

// File: tb/fp_status_reg_bench.sv
module fp_status_reg_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sw_we = 1'b0;
  logic [7:0]  sw_wbe = '0;
  logic [63:0] sw_wdata = '0;
  logic [63:0] sw_rdata;
  logic        upd_valid = 1'b0;
  logic [1:0]  upd_sf = '0;
  logic [5:0]  upd_exc = '0;
  logic [1:0]  ctl_sel = '0;
  logic [1:0]  ctl_rc, ctl_pc;
  logic        ctl_wre, ctl_ftz, ctl_td, trap_req;
  logic [5:0]  trap_cause;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  fp_status_reg u_fp_status_reg (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wbe(sw_wbe), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .upd_valid(upd_valid), .upd_sf(upd_sf), .upd_exc(upd_exc),
    .ctl_sel(ctl_sel), .ctl_rc(ctl_rc), .ctl_pc(ctl_pc), .ctl_wre(ctl_wre),
    .ctl_ftz(ctl_ftz), .ctl_td(ctl_td), .trap_req(trap_req), .trap_cause(trap_cause)
  );

  typedef struct {
    logic [63:0] rdata;
    logic        trap;
    logic [5:0]  cause;
    logic [6:0]  ctl;   // td ftz wre pc rc
    string       tag;
  } item_t;

  item_t exp_q[$];

  logic [5:0]  m_mask;
  logic [12:0] m_sf [4];

  function automatic logic [12:0] mkf(input logic ftz, input logic wre, input logic [1:0] pc,
                                      input logic [1:0] rc, input logic td, input logic [5:0] fl);
    return {fl, td, rc, pc, wre, ftz};
  endfunction

  function automatic logic [63:0] word_of(input logic [5:0] mk, input logic [12:0] f0,
      input logic [12:0] f1, input logic [12:0] f2, input logic [12:0] f3);
    logic [63:0] w = '0;
    w[5:0] = mk; w[18:6] = f0; w[31:19] = f1; w[44:32] = f2; w[57:45] = f3;
    return w;
  endfunction

  // exception order v z o u i d -> flag order v d z o u i
  function automatic logic [5:0] to_flags(input logic [5:0] e);
    return {e[4], e[3], e[2], e[1], e[5], e[0]};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic step(input bit r, input bit we, input logic [7:0] wbe, input logic [63:0] wd,
                      input bit uv, input logic [1:0] usf, input logic [5:0] ue,
                      input logic [1:0] cs, input string tag);
    item_t it;
    logic [5:0]  en;
    logic [63:0] w, bm;
    logic [12:0] f;
    @(negedge clk);
    rst = r; sw_we = we; sw_wbe = wbe; sw_wdata = wd;
    upd_valid = uv; upd_sf = usf; upd_exc = ue; ctl_sel = cs;
    if (r) begin
      m_mask = 6'h3F;
      m_sf[0] = mkf(0, 0, 2'b11, 2'b00, 0, 6'd0);
      for (int k = 1; k < 4; k++) m_sf[k] = mkf(0, 1, 2'b11, 2'b00, 0, 6'd0);
      en = '0;
    end else begin
      en = uv ? (ue & ~m_mask) : 6'd0;
      if (usf != 0 && m_sf[usf][6]) en = '0;
      if (uv && en == 0) m_sf[usf][12:7] = m_sf[usf][12:7] | to_flags(ue);
      w = word_of(m_mask, m_sf[0], m_sf[1], m_sf[2], m_sf[3]);
      bm = '0;
      for (int b = 0; b < 8; b++) bm[b*8 +: 8] = {8{we & wbe[b]}};
      w = (w & ~bm) | (wd & bm);
      m_mask = w[5:0];
      for (int k = 0; k < 4; k++) begin
        f = w[6 + 13*k +: 13];
        if (f[3:2] == 2'b01) f[3:2] = 2'b11;
        if (k == 0) f[6] = 1'b0;
        m_sf[k] = f;
      end
    end
    it.rdata = word_of(m_mask, m_sf[0], m_sf[1], m_sf[2], m_sf[3]);
    it.trap  = |en;
    it.cause = en;
    f = m_sf[cs];
    it.ctl = {f[6] && (cs != 0), f[0], f[1], f[3:2], f[5:4]};
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      item_t e;
      e = exp_q.pop_front();
      check(sw_rdata == e.rdata, e.tag, "rdata", sw_rdata, e.rdata);
      check(trap_req == e.trap, e.tag, "trap_req", 64'(trap_req), 64'(e.trap));
      if (e.trap)
        check(trap_cause == e.cause, e.tag, "trap_cause", 64'(trap_cause), 64'(e.cause));
      check({ctl_td, ctl_ftz, ctl_wre, ctl_pc, ctl_rc} == e.ctl, e.tag, "ctl",
            64'({ctl_td, ctl_ftz, ctl_wre, ctl_pc, ctl_rc}), 64'(e.ctl));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    step(1, 0, 8'h00, '0, 0, 0, 0, 0, "R1");
    step(1, 0, 8'h00, '0, 0, 0, 0, 0, "R1");
    for (int c = 0; c < 4; c++) step(0, 0, 8'h00, '0, 0, 0, 0, 2'(c), "R1_R10");
    // all ones: reserved bits zero, user td reads zero, precision stays legal
    step(0, 1, 8'hFF, '1, 0, 0, 0, 0, "R2_R5_R9");
    step(0, 1, 8'hFF, word_of(6'h00, mkf(1, 0, 2'b10, 2'b10, 1, 6'd0),
                                     mkf(0, 1, 2'b01, 2'b01, 0, 6'd0),
                                     mkf(1, 1, 2'b00, 2'b11, 1, 6'd0),
                                     mkf(0, 0, 2'b11, 2'b00, 0, 6'd0)), 0, 0, 0, 1, "R2_R9_R10");
    // user field traps despite written td; flags untouched
    step(0, 0, 8'h00, '0, 1, 2'd0, 6'h10, 0, "R3_R5_R7");
    step(0, 0, 8'h00, '0, 0, 0, 0, 2, "R3_R10");
    // td in field 2 blocks trap, flags accumulate
    step(0, 0, 8'h00, '0, 1, 2'd2, 6'h04, 2, "R4_R6");
    // partial write of byte 0 only: masks all set, sf0 ftz/wre bits set
    step(0, 1, 8'h01, 64'hFFFF_FFFF_FFFF_FF00 | 64'hFF, 0, 0, 0, 0, "R11");
    step(0, 0, 8'h00, '0, 1, 2'd1, 6'h20, 1, "R6");
    step(0, 0, 8'h00, '0, 1, 2'd1, 6'h03, 1, "R6");
    // unmask invalid only, then trap on field 3: flags stay
    step(0, 1, 8'h01, 64'hFE, 0, 0, 0, 3, "R11");
    step(0, 0, 8'h00, '0, 1, 2'd3, 6'h11, 3, "R3_R7");
    // collisions
    step(0, 1, 8'h01, 64'hFF, 1, 2'd3, 6'h04, 3, "R8");
    step(0, 1, 8'hC0, 64'h0, 1, 2'd3, 6'h08, 3, "R8");
    step(0, 0, 8'h00, '0, 1, 2'd3, 6'h20, 3, "R6");
    lf = 16'hACE1;
    for (int i = 0; i < 64; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(0, lf[0] & lf[5], lf[15:8], {lf, ~lf, lf ^ 16'h5A5A, lf}, lf[1], lf[3:2], lf[9:4],
           lf[7:6], "R3_R6_R8_R10");
    end
    step(0, 0, 8'h00, '0, 0, 0, 0, 0, "R6");
    repeat (3) @(posedge clk);
    #2;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule